// File: doc/BRIEF.md
# Receive Squelch Data Qualifier

This block sits behind the slicer of a coaxial receiver. Every 10 ns it takes one sample of the digitized line level and one flag from the analog average-level comparator. From these it decides whether real receive data is present. A level change counts only when the comparator reports a valid DC level and the new level has held for a minimum number of samples. Shorter excursions are treated as noise.

Every accepted level change restarts a transition timer. Receive-data-valid is raised by an accepted change and stays high while accepted changes keep arriving close enough together. When changes stop for longer than the timer window, valid falls on its own. The differential line code driven toward the host then returns to the zero-differential idle code. While valid is high, the line code follows the filtered level.

Top module: `rx_squelch_qual`

## Requirements
- R1: While rst_ni is low, rx_valid_o is 0 and rx_line_o is the idle code 2'b00, and the filtered level is 0.
- R2: A slicer level that differs from the filtered level and is sampled on MIN_WIDTH (default 3) consecutive clock edges with dc_ok_i high becomes the filtered level at the third such edge. rx_valid_o rises at the following edge.
- R3: A slicer excursion lasting fewer than MIN_WIDTH samples changes neither the filtered level nor rx_valid_o, whether the block is idle or active.
- R4: While dc_ok_i is low, no level change is accepted, and rx_valid_o is 0 from the edge after dc_ok_i is sampled low.
- R5: rx_valid_o stays continuously high while accepted level changes reach the timer at most TIMEOUT (default 20) edges apart.
- R6: rx_valid_o falls TIMEOUT edges after the last accepted change reached the timer. rx_line_o then returns to 2'b00.
- R7: rx_line_o is 2'b10 when valid with level 1, 2'b01 when valid with level 0, and 2'b00 when not valid. The code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 100 MHz sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slicer_i | input | 1 | Sampled slicer level |
| dc_ok_i | input | 1 | Average DC level comparator reports a valid level |
| rx_valid_o | output | 1 | Receive data valid; enables the output line driver |
| rx_line_o | output | 2 | Differential line code: 10 positive, 01 negative, 00 idle |

## Verification
On every cycle the assertions check four things: the line code stays legal and has exactly one active leg while valid, a dropped DC flag clears valid one edge later, and the filtered level moves only after a qualified DC level and onto the sampled slicer value. A checker-side gap counter shows that valid never outlives the timer window after the last accepted change. Only the bench scenarios can show the exact edge counts. These are the three-sample acceptance point, the rejection of two-sample glitches both while idle and while active, and continuity at a spacing of exactly 20 samples against a one-cycle dropout at 21. They also show that a level seen while the DC flag was low is not taken later without a fresh qualified change.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    LINE_IDLE = 2'b00,
    LINE_NEG  = 2'b01,
    LINE_POS  = 2'b10
  } line_e;
endpackage

// File: rtl/rsq_pulse_filter.sv
module rsq_pulse_filter #(
  parameter int MIN_WIDTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic enable_i,
  output logic level_o,
  output logic edge_o
);
  localparam int RW = (MIN_WIDTH > 1) ? $clog2(MIN_WIDTH) : 1;

  logic [RW-1:0] run_q;
  logic          level_q;
  logic          edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      level_q <= 1'b0;
      edge_q  <= 1'b0;
    end else begin
      edge_q <= 1'b0;
      if (!enable_i || sample_i == level_q) begin
        run_q <= '0;
      end else if (run_q == RW'(MIN_WIDTH - 1)) begin
        level_q <= sample_i;
        edge_q  <= 1'b1;
        run_q   <= '0;
      end else begin
        run_q <= run_q + RW'(1);
      end
    end
  end

  assign level_o = level_q;
  assign edge_o  = edge_q;
endmodule

// File: rtl/rsq_transition_timer.sv
module rsq_transition_timer #(
  parameter int TIMEOUT = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic enable_i,
  output logic valid_o
);
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  logic [CW-1:0] cnt_q;
  logic          valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (!enable_i) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (edge_i) begin
      // a fresh edge wins over expiry in the same cycle
      cnt_q   <= '0;
      valid_q <= 1'b1;
    end else if (valid_q) begin
      if (cnt_q == CW'(TIMEOUT - 1)) begin
        cnt_q   <= '0;
        valid_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/rsq_line_driver.sv
module rsq_line_driver
  import rsq_pkg::*;
(
  input  logic  valid_i,
  input  logic  level_i,
  output line_e line_o
);
  always_comb begin
    if (!valid_i)     line_o = LINE_IDLE;
    else if (level_i) line_o = LINE_POS;
    else              line_o = LINE_NEG;
  end
endmodule

// File: rtl/rx_squelch_qual.sv
module rx_squelch_qual #(
  parameter int MIN_WIDTH = 3,
  parameter int TIMEOUT   = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slicer_i,
  input  logic       dc_ok_i,
  output logic       rx_valid_o,
  output logic [1:0] rx_line_o
);
  logic          level_q;
  logic          edge_q;
  logic          valid_q;
  rsq_pkg::line_e line_w;

  rsq_pulse_filter #(.MIN_WIDTH(MIN_WIDTH)) u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(slicer_i),
    .enable_i(dc_ok_i),
    .level_o (level_q),
    .edge_o  (edge_q)
  );

  rsq_transition_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (edge_q),
    .enable_i(dc_ok_i),
    .valid_o (valid_q)
  );

  rsq_line_driver u_driver (
    .valid_i(valid_q),
    .level_i(level_q),
    .line_o (line_w)
  );

  assign rx_valid_o = valid_q;
  assign rx_line_o  = line_w;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int TIMEOUT = 20
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       slicer_i,
  input logic       dc_ok_i,
  input logic       rx_valid_o,
  input logic [1:0] rx_line_o,
  input logic       level,
  input logic       edge_p
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [TW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= TW'(TIMEOUT);
    else if (edge_p)                 gap_q <= '0;
    else if (gap_q < TW'(TIMEOUT))   gap_q <= gap_q + TW'(1);
  end

  AST_NO_ILLEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_line_o != 2'b11);  // R7
  AST_ACTIVE_ONE_LEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $countones(rx_line_o) == 1);  // R7
  AST_DC_DROP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dc_ok_i |=> !rx_valid_o);  // R4
  AST_LEVEL_NEEDS_DC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level) |-> $past(dc_ok_i));  // R4
  AST_LEVEL_FOLLOWS_SLICER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level) |-> $past(slicer_i) == level);  // R2
  AST_RISE_FROM_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> $past(edge_p));  // R2
  AST_GAP_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> gap_q < TW'(TIMEOUT));  // R6
endmodule

bind rx_squelch_qual rsq_checker #(.TIMEOUT(TIMEOUT)) u_rsq_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .slicer_i  (slicer_i),
  .dc_ok_i   (dc_ok_i),
  .rx_valid_o(rx_valid_o),
  .rx_line_o (rx_line_o),
  .level     (level_q),
  .edge_p    (edge_q)
);

// File: tb/rx_squelch_qual_bench.sv
module rx_squelch_qual_bench;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       slicer_i;
  logic       dc_ok_i;
  logic       rx_valid_o;
  logic [1:0] rx_line_o;

  always #2 clk = ~clk;

  rx_squelch_qual u_rx_squelch_qual (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .slicer_i  (slicer_i),
    .dc_ok_i   (dc_ok_i),
    .rx_valid_o(rx_valid_o),
    .rx_line_o (rx_line_o)
  );

  typedef struct packed {
    int         cyc;
    logic       v;
    logic [1:0] l;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic v, logic [1:0] l, logic ev, logic [1:0] el);
    checks++;
    if (v !== ev || l !== el) begin
      errors++;
      $display("FAIL %s cyc=%0d: valid=%0b line=%02b expected valid=%0b line=%02b",
               tag, cyc, v, l, ev, el);
    end
  endtask

  task automatic expect_at(int c, logic v, logic [1:0] l, string tag);
    exp_t e;
    e.cyc = c; e.v = v; e.l = l;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic step(logic s, logic d);
    slicer_i = s;
    dc_ok_i  = d;
    @(posedge clk);
    #1;
  endtask

  task automatic run(logic s, logic d, int n);
    repeat (n) step(s, d);
  endtask

  // monitor: pop expected items due this cycle
  always @(negedge clk) begin
    exp_t  e;
    string t;
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e.cyc < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s: item for cyc=%0d missed, actual cyc=%0d expected cyc=%0d",
                 t, e.cyc, cyc, e.cyc);
      end else begin
        check(t, rx_valid_o, rx_line_o, e.v, e.l);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    rst_ni   = 1'b0;
    slicer_i = 1'b1;
    dc_ok_i  = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", rx_valid_o, rx_line_o, 1'b0, 2'b00);
    slicer_i = 1'b0;
    rst_ni   = 1'b1;
    run(0, 1, 2);

    // R3: two-sample glitch while idle
    base = cyc;
    expect_at(base + 3, 1'b0, 2'b00, "R3 idle glitch");
    expect_at(base + 5, 1'b0, 2'b00, "R3 idle glitch");
    run(1, 1, 2); run(0, 1, 3);

    // R2 acceptance, R7 codes, R3 glitch while active, R6 timeout
    base = cyc;
    expect_at(base + 3,  1'b0, 2'b00, "R2 before valid");
    expect_at(base + 4,  1'b1, 2'b10, "R2 valid rises");
    expect_at(base + 7,  1'b1, 2'b01, "R7 negative code");
    expect_at(base + 10, 1'b1, 2'b01, "R3 active glitch");
    expect_at(base + 27, 1'b1, 2'b01, "R6 last valid cycle");
    expect_at(base + 28, 1'b0, 2'b00, "R6 timeout idle");
    run(1, 1, 4); run(0, 1, 3); run(1, 1, 2); run(0, 1, 21);

    // R5: spacing 10
    base = cyc;
    expect_at(base + 3,  1'b0, 2'b00, "R7 idle code");
    expect_at(base + 10, 1'b1, 2'b10, "R5 spacing 10");
    expect_at(base + 15, 1'b1, 2'b01, "R7 negative code");
    expect_at(base + 50, 1'b1, 2'b10, "R5 spacing 10");
    expect_at(base + 75, 1'b1, 2'b01, "R5 spacing 10");
    expect_at(base + 93, 1'b1, 2'b01, "R6 last valid cycle");
    expect_at(base + 94, 1'b0, 2'b00, "R6 timeout idle");
    for (int k = 0; k < 4; k++) begin
      run(1, 1, 10); run(0, 1, 10);
    end
    run(0, 1, 20);

    // R5: spacing exactly TIMEOUT
    base = cyc;
    expect_at(base + 24, 1'b1, 2'b01, "R5 spacing 20");
    expect_at(base + 44, 1'b1, 2'b10, "R5 spacing 20");
    expect_at(base + 84, 1'b0, 2'b00, "R6 timeout idle");
    run(1, 1, 20); run(0, 1, 20); run(1, 1, 20); run(0, 1, 25);

    // spacing 21: one-cycle dropout
    base = cyc;
    expect_at(base + 24, 1'b0, 2'b00, "R6 spacing 21 drop");
    expect_at(base + 25, 1'b1, 2'b01, "R5 restart after drop");
    run(1, 1, 21); run(0, 1, 24);

    // R4: DC qualification
    base = cyc;
    expect_at(base + 5,  1'b0, 2'b00, "R4 dc low blocks");
    expect_at(base + 9,  1'b1, 2'b10, "R2 accept after dc");
    expect_at(base + 10, 1'b0, 2'b00, "R4 dc drop clears");
    expect_at(base + 20, 1'b0, 2'b00, "R4 no stale accept");
    expect_at(base + 24, 1'b1, 2'b01, "R2 accept level 0");
    expect_at(base + 44, 1'b0, 2'b00, "R6 timeout idle");
    run(1, 0, 5); run(1, 1, 4); run(1, 0, 1); run(0, 0, 5);
    run(1, 1, 5); run(0, 1, 4); run(0, 1, 21);

    run(0, 1, 2);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: pending=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule